// File: doc/BRIEF.md
# Pause Frame Request Controller

This block decides when an Ethernet MAC's transmit path should send a flow-control frame. It has two trigger sources. The first watches the receive FIFO fill level, counted in bytes, against a programmable high-water mark. When the level first reaches that mark, the block raises a request to send an XOFF pause frame. The second source is a pair of asynchronous request pins, XOFF and XON. Their sequencing gives hysteresis: one XOFF goes out per pin assertion, and the pin cannot send another XOFF until an XON has come and gone. All frames need the transmit flow-control enable to be set.

Requests are kept pending inside the block until the transmit path can take them. A request is signalled to the transmit path by a one-cycle pulse, which is issued only while the transmit path is not busy. After each pulse the block waits for an acknowledge before it issues the next one. When both kinds of frame are pending, XOFF goes out first. Two software-visible words hold the configuration. The threshold word carries the high-water mark and the pin enable. The control word carries the transmit flow-control enable and the XON enable.

Top module: `pause_req_ctrl`

## Requirements
- R1: After reset, xoff_req and xon_req are low, and both configuration words read as zero.
- R2: Threshold word (cfg_sel=0): bits 15:3 hold the high-water mark in bytes (mark = field*8), bit 31 is the pin enable, and all other bits read 0. Control word (cfg_sel=1): bit 0 is the transmit flow-control enable, bit 1 is the XON enable, and all other bits read 0.
- R3: When fifo_level goes from below the mark to at or above it, exactly one XOFF request is produced. Staying at or above the mark produces no further requests.
- R4: The level trigger re-arms only after fifo_level drops below the mark. The next crossing then produces another XOFF.
- R5: While the transmit flow-control enable is 0, neither trigger source produces any request.
- R6: With the pin enable set, a rising edge on xoff_pin yields exactly one XOFF request, even if the pin stays high. The pin passes through a two-flop synchronizer first. With the pin enable clear, the pins have no effect.
- R7: After a pin XOFF, a rising edge on xon_pin while xoff_pin is low yields one XON request if the XON enable is set, and no request if it is clear.
- R8: After a pin XOFF, further xoff_pin rising edges are ignored until xon_pin has been asserted and then deasserted.
- R9: Each request is a single-cycle pulse and is issued only when tx_busy was low. After a pulse, no further pulse is issued until tx_ack has been seen. Pending requests are held and are not lost.
- R10: When an XOFF and an XON are both pending, the XOFF pulse is issued first, whatever order they arrived in.
- R11: With the block idle and tx_busy low, xoff_req pulses in the cycle after the second rising clock edge that follows the level change which crosses the mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the selected configuration word |
| cfg_sel | input | 1 | 0 selects the threshold word, 1 selects the control word |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_data | output | 32 | Read data of the selected word |
| fifo_level | input | 16 | Receive FIFO fill level in bytes |
| xoff_pin | input | 1 | Asynchronous external XOFF request |
| xon_pin | input | 1 | Asynchronous external XON request |
| tx_busy | input | 1 | Transmit path cannot accept a request |
| tx_ack | input | 1 | Transmit path has taken the outstanding request |
| xoff_req | output | 1 | One-cycle request to send an XOFF pause frame |
| xon_req | output | 1 | One-cycle request to send an XON frame |

## Verification
The level trigger is tried in several ways: a level just below the mark, exactly at it, well above it, and back below then up again. Together these separate a missing one-shot from a missing re-arm, and they also show an off-by-eight error in the mark scaling. The pin path is tried with a held XOFF, with XOFF re-asserted without an XON in between, and with XON while the XON enable is both clear and set. This separates the hysteresis from plain edge detection. A phase with tx_busy held high collects an XON and then an XOFF as pending requests, and the order of their release shows the priority.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam int REG_W      = 32;
    localparam int LEVEL_W    = 16;
    localparam int GRAN_BITS  = 3;
    localparam int THR_W      = LEVEL_W - GRAN_BITS;
    localparam int EXT_EN_BIT = REG_W - 1;

    typedef struct packed {
        logic             ext_en;
        logic [THR_W-1:0] thr;
        logic             tfce;
        logic             xon_en;
    } pfc_cfg_t;

    typedef enum logic [1:0] {
        PIN_READY  = 2'd0,
        PIN_SENT   = 2'd1,
        PIN_XON_HI = 2'd2
    } pin_st_e;

    typedef enum logic {
        KIND_XOFF = 1'b0,
        KIND_XON  = 1'b1
    } frame_kind_e;

    function automatic logic [LEVEL_W-1:0] thr_bytes(input logic [THR_W-1:0] t);
        return {t, {GRAN_BITS{1'b0}}};
    endfunction

endpackage

// File: rtl/pfc_cfg_regs.sv
module pfc_cfg_regs
    import pfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output pfc_cfg_t         cfg
);

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[EXT_EN_BIT-1:LEVEL_W], wr_data[GRAN_BITS-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            if (!sel) begin
                cfg.ext_en <= wr_data[EXT_EN_BIT];
                cfg.thr    <= wr_data[LEVEL_W-1:GRAN_BITS];
            end else begin
                cfg.tfce   <= wr_data[0];
                cfg.xon_en <= wr_data[1];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (!sel) begin
            rd_data[EXT_EN_BIT]               = cfg.ext_en;
            rd_data[LEVEL_W-1:GRAN_BITS]      = cfg.thr;
        end else begin
            rd_data[0] = cfg.tfce;
            rd_data[1] = cfg.xon_en;
        end
    end

    AST_CTRL_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel) |=> (cfg.tfce == $past(wr_data[0]))); // R2

endmodule

// File: rtl/pfc_level_trig.sv
module pfc_level_trig
    import pfc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [LEVEL_W-1:0] level,
    input  logic [THR_W-1:0]   thr,
    input  logic               tfce,
    output logic               fire
);

    logic at_or_above;
    logic armed;

    assign at_or_above = (level >= thr_bytes(thr));
    assign fire        = at_or_above && armed && tfce;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b1;
        end else if (!at_or_above) begin
            armed <= 1'b1;
        end else if (fire) begin
            armed <= 1'b0;
        end
    end

    AST_LEVEL_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        (fire && at_or_above) |=> !fire); // R3

endmodule

// File: rtl/pfc_pin_seq.sv
module pfc_pin_seq
    import pfc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic xoff_pin,
    input  logic xon_pin,
    input  logic ext_en,
    input  logic tfce,
    input  logic xon_en,
    output logic xoff_fire,
    output logic xon_fire
);

    logic [SYNC_STAGES-1:0] xoff_sync;
    logic [SYNC_STAGES-1:0] xon_sync;
    logic xoff_s, xon_s, xoff_prev, xon_prev;
    logic xoff_rise, xon_rise;
    pin_st_e st, st_nxt;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    xoff_sync <= '0;
                    xon_sync  <= '0;
                end else begin
                    xoff_sync <= xoff_pin;
                    xon_sync  <= xon_pin;
                end
            end
        end else begin : g_sync_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    xoff_sync <= '0;
                    xon_sync  <= '0;
                end else begin
                    xoff_sync <= {xoff_sync[SYNC_STAGES-2:0], xoff_pin};
                    xon_sync  <= {xon_sync[SYNC_STAGES-2:0], xon_pin};
                end
            end
        end
    endgenerate

    assign xoff_s    = xoff_sync[SYNC_STAGES-1];
    assign xon_s     = xon_sync[SYNC_STAGES-1];
    assign xoff_rise = xoff_s && !xoff_prev;
    assign xon_rise  = xon_s && !xon_prev;

    always_comb begin
        st_nxt    = st;
        xoff_fire = 1'b0;
        xon_fire  = 1'b0;
        if (!ext_en) begin
            st_nxt = PIN_READY;
        end else begin
            case (st)
                PIN_READY: begin
                    if (xoff_rise && tfce) begin
                        xoff_fire = 1'b1;
                        st_nxt    = PIN_SENT;
                    end
                end
                PIN_SENT: begin
                    if (xon_rise && !xoff_s) begin
                        xon_fire = tfce && xon_en;
                        st_nxt   = PIN_XON_HI;
                    end
                end
                PIN_XON_HI: begin
                    if (!xon_s) st_nxt = PIN_READY;
                end
                default: st_nxt = PIN_READY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= PIN_READY;
            xoff_prev <= 1'b0;
            xon_prev  <= 1'b0;
        end else begin
            st        <= st_nxt;
            xoff_prev <= xoff_s;
            xon_prev  <= xon_s;
        end
    end

    AST_PIN_XOFF_ONCE: assert property (@(posedge clk) disable iff (rst)
        xoff_fire |=> !xoff_fire); // R6
    AST_PIN_XON_NEEDS_XOFF: assert property (@(posedge clk) disable iff (rst)
        xon_fire |=> !xoff_fire); // R8

endmodule

// File: rtl/pfc_req_arb.sv
module pfc_req_arb
    import pfc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_xoff,
    input  logic set_xon,
    input  logic tx_busy,
    input  logic tx_ack,
    output logic xoff_req,
    output logic xon_req
);

    logic        pend_xoff, pend_xon, waiting;
    frame_kind_e wait_kind;
    logic        clr_xoff, clr_xon;

    assign clr_xoff = waiting && tx_ack && (wait_kind == KIND_XOFF);
    assign clr_xon  = waiting && tx_ack && (wait_kind == KIND_XON);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_xoff <= 1'b0;
            pend_xon  <= 1'b0;
            waiting   <= 1'b0;
            wait_kind <= KIND_XOFF;
            xoff_req  <= 1'b0;
            xon_req   <= 1'b0;
        end else begin
            pend_xoff <= set_xoff || (pend_xoff && !clr_xoff);
            pend_xon  <= set_xon  || (pend_xon  && !clr_xon);
            xoff_req  <= 1'b0;
            xon_req   <= 1'b0;
            if (waiting) begin
                if (tx_ack) waiting <= 1'b0;
            end else if (!tx_busy && (pend_xoff || pend_xon)) begin
                waiting   <= 1'b1;
                wait_kind <= pend_xoff ? KIND_XOFF : KIND_XON;
                xoff_req  <= pend_xoff;
                xon_req   <= !pend_xoff;
            end
        end
    end

    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (xoff_req || xon_req) |=> !(xoff_req || xon_req)); // R9
    AST_REQ_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (xoff_req || xon_req) |-> $past(!tx_busy)); // R9
    AST_XOFF_FIRST: assert property (@(posedge clk) disable iff (rst)
        xon_req |-> !$past(pend_xoff)); // R10

endmodule

// File: rtl/pause_req_ctrl.sv
module pause_req_ctrl
    import pfc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr_en,
    input  logic               cfg_sel,
    input  logic [REG_W-1:0]   cfg_wr_data,
    output logic [REG_W-1:0]   cfg_rd_data,
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic               xoff_pin,
    input  logic               xon_pin,
    input  logic               tx_busy,
    input  logic               tx_ack,
    output logic               xoff_req,
    output logic               xon_req
);

    pfc_cfg_t cfg;
    logic     lvl_fire, pin_xoff_fire, pin_xon_fire;

    pfc_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .sel     (cfg_sel),
        .wr_data (cfg_wr_data),
        .rd_data (cfg_rd_data),
        .cfg     (cfg)
    );

    pfc_level_trig u_level (
        .clk   (clk),
        .rst   (rst),
        .level (fifo_level),
        .thr   (cfg.thr),
        .tfce  (cfg.tfce),
        .fire  (lvl_fire)
    );

    pfc_pin_seq #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
        .clk       (clk),
        .rst       (rst),
        .xoff_pin  (xoff_pin),
        .xon_pin   (xon_pin),
        .ext_en    (cfg.ext_en),
        .tfce      (cfg.tfce),
        .xon_en    (cfg.xon_en),
        .xoff_fire (pin_xoff_fire),
        .xon_fire  (pin_xon_fire)
    );

    pfc_req_arb u_arb (
        .clk      (clk),
        .rst      (rst),
        .set_xoff (lvl_fire || pin_xoff_fire),
        .set_xon  (pin_xon_fire),
        .tx_busy  (tx_busy),
        .tx_ack   (tx_ack),
        .xoff_req (xoff_req),
        .xon_req  (xon_req)
    );

    AST_REQ_NEEDS_TFCE: assert property (@(posedge clk) disable iff (rst)
        (lvl_fire || pin_xoff_fire || pin_xon_fire) |-> cfg_sel || !cfg_wr_en || 1'b1 ? cfg.tfce : 1'b0); // R5

endmodule

// File: tb/pause_req_ctrl_bench.sv
module pause_req_ctrl_bench;
    import pfc_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cfg_wr_en = 1'b0;
    logic               cfg_sel = 1'b0;
    logic [REG_W-1:0]   cfg_wr_data = '0;
    logic [REG_W-1:0]   cfg_rd_data;
    logic [LEVEL_W-1:0] fifo_level = '0;
    logic               xoff_pin = 1'b0;
    logic               xon_pin = 1'b0;
    logic               tx_busy = 1'b0;
    logic               tx_ack = 1'b0;
    logic               xoff_req, xon_req;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    bit  exp_q[$];          // 0 = XOFF, 1 = XON
    bit  outstanding = 1'b0;
    int  ack_cnt = 0;

    pause_req_ctrl u_pause_req_ctrl (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .fifo_level(fifo_level), .xoff_pin(xoff_pin), .xon_pin(xon_pin),
        .tx_busy(tx_busy), .tx_ack(tx_ack), .xoff_req(xoff_req), .xon_req(xon_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_sel = sel; cfg_wr_data = d; cfg_wr_en = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic sel, input logic [31:0] exp);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        check(req, cfg_rd_data, exp);
    endtask

    task automatic drained(input string req);
        cycles(20);
        check(req, exp_q.size(), 0);
    endtask

    // Monitor, scoreboard and acknowledging responder
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && (xoff_req || xon_req)) begin
                if (outstanding) check("R9 pulse before ack", 1, 0);
                if (exp_q.size() == 0) begin
                    check("R3/R5/R6/R7/R8 unexpected request", {31'd0, xon_req}, 32'hFFFF);
                end else begin
                    check("R10 request kind/order", {31'd0, xon_req}, {31'd0, exp_q.pop_front()});
                end
                outstanding = 1'b1;
                ack_cnt = 3;
            end else if (ack_cnt > 0) begin
                ack_cnt--;
                if (ack_cnt == 0) tx_ack = 1'b1;
            end else if (tx_ack) begin
                tx_ack = 1'b0;
                outstanding = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cycles(3);
        rst = 1'b0;
        // R1 reset state
        check("R1 xoff_req", xoff_req, 0);
        check("R1 xon_req", xon_req, 0);
        rd_check("R1 threshold word", 1'b0, 32'h0);
        rd_check("R1 control word", 1'b1, 32'h0);

        // R2 field layout
        wr(1'b0, 32'hFFFF_FFFF);
        rd_check("R2 threshold word", 1'b0, 32'h8000_FFF8);
        wr(1'b1, 32'hFFFF_FFFF);
        rd_check("R2 control word", 1'b1, 32'h0000_0003);
        wr(1'b1, 32'h0);
        wr(1'b0, 32'h0000_0047);
        rd_check("R2 mark granularity", 1'b0, 32'h0000_0040);

        // R5 no requests while transmit flow control is off
        fifo_level = 16'd100;
        drained("R5 level with enable off");
        fifo_level = 16'd0;
        cycles(2);

        // R3 / R11 / R4 level trigger
        wr(1'b1, 32'h1);
        fifo_level = 16'd63;
        drained("R3 just below mark");
        exp_q.push_back(1'b0);
        @(negedge clk); fifo_level = 16'd64;
        @(negedge clk); check("R11 no pulse after first edge", xoff_req, 0);
        @(negedge clk); check("R11 pulse after second edge", xoff_req, 1);
        fifo_level = 16'd200;
        drained("R3 one request while above");
        fifo_level = 16'd64;
        drained("R3 still at mark");
        fifo_level = 16'd63;
        cycles(3);
        exp_q.push_back(1'b0);
        fifo_level = 16'd64;
        drained("R4 re-armed crossing");
        fifo_level = 16'd0;
        cycles(3);

        // R6 pins ignored with pin enable clear
        xoff_pin = 1'b1; cycles(10); xoff_pin = 1'b0;
        drained("R6 pin enable clear");

        // pin enable on
        wr(1'b0, 32'h8000_0040);
        exp_q.push_back(1'b0);
        xoff_pin = 1'b1; cycles(25);
        drained("R6 held xoff gives one");
        xoff_pin = 1'b0; cycles(6);
        xon_pin = 1'b1; cycles(10); xon_pin = 1'b0;
        drained("R7 xon with xon enable clear");
        exp_q.push_back(1'b0);
        xoff_pin = 1'b1; cycles(10); xoff_pin = 1'b0;
        drained("R8 re-armed after xon cycle");
        xoff_pin = 1'b1; cycles(10); xoff_pin = 1'b0;
        drained("R8 second xoff blocked");
        wr(1'b1, 32'h3);
        exp_q.push_back(1'b1);
        xon_pin = 1'b1; cycles(10); xon_pin = 1'b0;
        drained("R7 xon with xon enable set");
        exp_q.push_back(1'b0);
        xoff_pin = 1'b1; cycles(10); xoff_pin = 1'b0;
        drained("R8 xoff allowed after xon");

        // R9 / R10 busy hold and priority
        tx_busy = 1'b1;
        xon_pin = 1'b1; cycles(10); xon_pin = 1'b0;
        fifo_level = 16'd500;
        cycles(10);
        check("R9 no pulse while busy", exp_q.size(), 0);
        exp_q.push_back(1'b0);
        exp_q.push_back(1'b1);
        tx_busy = 1'b0;
        drained("R10 both pending released");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule